// File: doc/BRIEF.md
# Serial quad DAC frame encoder

This block takes a list of DAC updates from a byte stream and turns each update into a two-byte serial frame for an external four-channel DAC. The first byte that the stream delivers while the block is idle is a count N. N pairs follow, each made of a value byte and then a channel byte. For every pair the block pulls the frame-select line low, shifts sixteen bits out on a clock and data pair, and raises the select line again. When the whole list is finished it pulses a done output.

Each frame packs an 8-bit code across its two bytes. The first byte holds the channel number and a flag that asks the DAC to update its output at once. The second byte carries the rest of the code. The serial clock comes from a programmable divider of the system clock. Consecutive frames are separated by a guaranteed idle time with the select line high.

Top module: `dac_frame_enc`

## Requirements
- R1: After reset, syncN is 1, sclk is 0, mosi is 0, done is 0 and inReady is 1.
- R2: The first byte accepted in idle (inValid and inReady both high at a clock edge) is the pair count N. The next 2N accepted bytes are read as value, channel, value, channel and so on. Each pair gives exactly one frame, and frames go out in list order.
- R3: Bits 15:8 of the frame (the first byte on the wire) are channel[1:0] in bits 15:14, 0 in bit 13, 1 in bit 12 (update-now flag) and value[7:4] in bits 11:8. Bits 7:2 of the channel byte are ignored.
- R4: Bits 7:0 of the frame (the second byte) are value[3:0] in bits 7:4 and zero in bits 3:0.
- R5: Bits are sent most significant first. mosi changes only in a cycle where sclk rises, and it holds steady across each falling sclk edge. Every frame has exactly 16 falling sclk edges while syncN is low. sclk is low whenever syncN is high.
- R6: syncN goes low at least HALF_DIV clock cycles before the first rising sclk edge of a frame. It goes high only after the 16th falling edge.
- R7: Between two frames, syncN stays high for at least GAP_SCLK full sclk periods (2*GAP_SCLK*HALF_DIV clock cycles).
- R8: A count of 0 produces no frame, and done is high in the cycle right after the count byte is accepted.
- R9: done is a single-cycle pulse. It is given once per list, after the last frame of that list.
- R10: inReady is low while syncN is low, so no stream byte is taken during a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Stream byte present |
| inByte | input | 8 | Stream byte (count, value or channel) |
| inReady | output | 1 | Block takes the byte at this edge if inValid |
| syncN | output | 1 | Active-low frame select to the DAC |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data, MSB first |
| done | output | 1 | One-cycle pulse at the end of a list |

## Verification
Two events can fall in the same clock edge. First, a rising sclk edge and the load of the next data bit happen together. A falling edge must never carry a data change. Second, the end of the inter-frame gap and the end-of-list decision happen together, and that decision picks either a done pulse or a fetch of the next value byte. The bench checks the first case cycle by cycle: at every negative clock edge it compares mosi and sclk with their values one cycle earlier. It provokes the second case with lists of six pairs, one pair and zero pairs, and judges it by the number of frames captured when each done pulse appears.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

  localparam int FRAME_BITS = 16;

  typedef struct packed {
    logic latchVal;
    logic loadFrame;
    logic run;
    logic shiftEn;
  } dfeStrobe_t;

  function automatic logic [FRAME_BITS-1:0] buildFrame(input logic [7:0] val,
                                                       input logic [7:0] chan);
    return {chan[1:0], 1'b0, 1'b1, val[7:4], val[3:0], 4'b0000};
  endfunction

endpackage

// File: rtl/dfe_datapath.sv
module dfe_datapath
  import dfe_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dfeStrobe_t stb,
  input  logic [7:0] inByte,
  output logic       halfTick,
  output logic       bitsDone,
  output logic       sclk,
  output logic       mosi
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [DIV_W-1:0]      divCnt;
  logic [7:0]            valBuf;
  logic [FRAME_BITS-1:0] shReg;
  logic [CNT_W-1:0]      fallCnt;
  logic                  sclkR;
  logic                  mosiR;
  logic                  lastFall;

  assign halfTick = stb.run && (divCnt == DIV_W'(HALF_DIV - 1));
  assign lastFall = (fallCnt == CNT_W'(FRAME_BITS));
  assign bitsDone = stb.shiftEn && halfTick && lastFall;
  assign sclk     = sclkR;
  assign mosi     = mosiR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!stb.run || halfTick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valBuf  <= '0;
      shReg   <= '0;
      fallCnt <= '0;
      sclkR   <= 1'b0;
      mosiR   <= 1'b0;
    end else begin
      if (stb.latchVal) begin
        valBuf <= inByte;
      end
      if (stb.loadFrame) begin
        shReg   <= buildFrame(valBuf, inByte);
        fallCnt <= '0;
        sclkR   <= 1'b0;
        mosiR   <= 1'b0;
      end else if (stb.shiftEn && halfTick && !lastFall) begin
        sclkR <= !sclkR;
        if (!sclkR) begin
          mosiR <= shReg[FRAME_BITS-1];
          shReg <= {shReg[FRAME_BITS-2:0], 1'b0};
        end else begin
          fallCnt <= fallCnt + 1'b1;
        end
      end
    end
  end

  AST_MOSI_HOLD_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclkR) |-> $stable(mosiR)); // R5

  AST_END_WITH_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    bitsDone |-> !sclkR); // R6

endmodule

// File: rtl/dfe_ctrl.sv
module dfe_ctrl
  import dfe_pkg::*;
#(
  parameter int GAP_SCLK = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  logic       halfTick,
  input  logic       bitsDone,
  output logic       inReady,
  output logic       syncN,
  output logic       done,
  output dfeStrobe_t stb
);

  localparam int GAP_HALVES = 2 * GAP_SCLK;
  localparam int GAP_W = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_VAL, S_CHAN, S_LEAD, S_SHIFT, S_GAP, S_DONE
  } ctrlState_t;

  ctrlState_t state;
  logic [7:0] remaining;
  logic [GAP_W-1:0] gapCnt;
  logic accept;

  assign inReady = (state == S_IDLE) || (state == S_VAL) || (state == S_CHAN);
  assign accept  = inReady && inValid;
  assign syncN   = !((state == S_LEAD) || (state == S_SHIFT));
  assign done    = (state == S_DONE);

  always_comb begin
    stb.latchVal  = (state == S_VAL) && accept;
    stb.loadFrame = (state == S_CHAN) && accept;
    stb.run       = (state == S_LEAD) || (state == S_SHIFT) || (state == S_GAP);
    stb.shiftEn   = (state == S_SHIFT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remaining <= '0;
      gapCnt    <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          remaining <= inByte;
          state     <= (inByte == 8'd0) ? S_DONE : S_VAL;
        end
        S_VAL:   if (accept) state <= S_CHAN;
        S_CHAN:  if (accept) state <= S_LEAD;
        S_LEAD:  if (halfTick) state <= S_SHIFT;
        S_SHIFT: if (bitsDone) begin
          remaining <= remaining - 1'b1;
          gapCnt    <= '0;
          state     <= S_GAP;
        end
        S_GAP: if (halfTick) begin
          if (gapCnt == GAP_W'(GAP_HALVES - 1)) begin
            state <= (remaining == 8'd0) ? S_DONE : S_VAL;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ZERO_COUNT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && inValid && inByte == 8'd0) |=> done); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_SHIFT_ENDS_IN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    bitsDone |=> (syncN && !inReady)); // R10

endmodule

// File: rtl/dac_frame_enc.sv
module dac_frame_enc
  import dfe_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int GAP_SCLK = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inByte,
  output logic       inReady,
  output logic       syncN,
  output logic       sclk,
  output logic       mosi,
  output logic       done
);

  localparam int GAP_MIN = 2 * GAP_SCLK * HALF_DIV;
  localparam int HI_W = $clog2(GAP_MIN + 1);

  dfeStrobe_t stb;
  logic halfTick;
  logic bitsDone;

  dfe_ctrl #(.GAP_SCLK(GAP_SCLK)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inByte   (inByte),
    .halfTick (halfTick),
    .bitsDone (bitsDone),
    .inReady  (inReady),
    .syncN    (syncN),
    .done     (done),
    .stb      (stb)
  );

  dfe_datapath #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inByte   (inByte),
    .halfTick (halfTick),
    .bitsDone (bitsDone),
    .sclk     (sclk),
    .mosi     (mosi)
  );

  logic [HI_W-1:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt <= HI_W'(GAP_MIN);
    end else if (!syncN) begin
      hiCnt <= '0;
    end else if (hiCnt < HI_W'(GAP_MIN)) begin
      hiCnt <= hiCnt + 1'b1;
    end
  end

  AST_SYNC_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncN) |-> (hiCnt >= HI_W'(GAP_MIN))); // R7

  AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    syncN |-> !sclk); // R5

endmodule

// File: tb/dac_frame_enc_bench.sv
module dac_frame_enc_bench;

  localparam int HALF = 2;
  localparam int GAPS = 2;
  localparam int GAP_MIN = 2 * GAPS * HALF;
  localparam int NVEC = 6;

  // {value, channel, expected frame}
  localparam logic [31:0] VECS [NVEC] = '{
    {8'hA5, 8'h02, 16'h9A50},
    {8'h00, 8'h00, 16'h1000},
    {8'hFF, 8'h03, 16'hDFF0},
    {8'h3C, 8'hFD, 16'h53C0},
    {8'h81, 8'h80, 16'h1810},
    {8'h5A, 8'h07, 16'hD5A0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inByte = '0;
  logic inReady, syncN, sclk, mosi, done;

  always #5 clk = !clk;

  dac_frame_enc #(.HALF_DIV(HALF), .GAP_SCLK(GAPS)) u_dac_frame_enc (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .inReady(inReady), .syncN(syncN), .sclk(sclk), .mosi(mosi), .done(done)
  );

  int checks = 0;
  int fails = 0;
  logic [15:0] capWord [16];
  int capBits [16];
  int capN = 0;
  logic [15:0] word = '0;
  int bitN = 0;
  int hiRun = 1000;
  int leadRun = 0;
  bit seenRise = 0;
  int mosiViol = 0, sclkViol = 0, gapViol = 0, leadViol = 0;
  int readyViol = 0, doneViol = 0, doneCount = 0;
  logic prevSyncN = 1'b1, prevSclk = 1'b0, prevMosi = 1'b0, prevDone = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (prevSyncN && !syncN) begin
        if (capN > 0 && hiRun < GAP_MIN) gapViol++;
        word = '0; bitN = 0; leadRun = 0; seenRise = 0;
      end
      if (!syncN) begin
        if (!seenRise && !sclk) leadRun++;
        if (!seenRise && sclk && !prevSclk) begin
          seenRise = 1;
          if (leadRun < HALF) leadViol++;
        end
        if (prevSclk && !sclk) begin
          word = {word[14:0], mosi};
          bitN++;
        end
        if (!prevSyncN && (mosi != prevMosi) && !(sclk && !prevSclk)) mosiViol++;
        if (inReady) readyViol++;
      end
      if (syncN && sclk) sclkViol++;
      if (!prevSyncN && syncN) begin
        if (capN < 16) begin
          capWord[capN] = word;
          capBits[capN] = bitN;
        end
        capN++;
        hiRun = 0;
      end
      if (syncN) hiRun++;
      if (done) doneCount++;
      if (done && prevDone) doneViol++;
    end
    prevSyncN = syncN; prevSclk = sclk; prevMosi = mosi; prevDone = done;
  end

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1;
    inByte = b;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitDone(input int target);
    while (doneCount < target) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(syncN == 1'b1, "R1 syncN", syncN, 1);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(mosi == 1'b0, "R1 mosi", mosi, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(inReady == 1'b1, "R1 inReady", inReady, 1);
    rstN = 1'b1;

    // table-driven list of six pairs
    sendByte(8'(NVEC));
    for (int i = 0; i < NVEC; i++) begin
      sendByte(VECS[i][31:24]);
      sendByte(VECS[i][23:16]);
    end
    waitDone(1);
    chk(capN == NVEC, "R9 frames at done", capN, NVEC);
    for (int i = 0; i < NVEC; i++) begin
      chk(capWord[i] == VECS[i][15:0], "R2 R3 R4 frame word", capWord[i], VECS[i][15:0]);
      chk(capBits[i] == 16, "R5 falling edges per frame", capBits[i], 16);
    end

    // zero count
    @(negedge clk);
    inValid = 1'b1;
    inByte = 8'h00;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R8 done after zero count", done, 1);
    inValid = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R9 done pulse width", done, 0);
    repeat (40) @(negedge clk);
    chk(capN == NVEC, "R8 no frame for zero count", capN, NVEC);

    // single-pair list
    sendByte(8'd1);
    sendByte(8'h42);
    sendByte(8'h01);
    waitDone(3);
    chk(capN == NVEC + 1, "R2 one frame for one pair", capN, NVEC + 1);
    chk(capWord[NVEC] == 16'h5420, "R3 R4 single frame", capWord[NVEC], 16'h5420);
    repeat (10) @(negedge clk);

    chk(mosiViol == 0, "R5 mosi change off rising edge", mosiViol, 0);
    chk(sclkViol == 0, "R5 sclk high with sync high", sclkViol, 0);
    chk(leadViol == 0, "R6 sync lead", leadViol, 0);
    chk(gapViol == 0, "R7 sync gap", gapViol, 0);
    chk(readyViol == 0, "R10 ready during frame", readyViol, 0);
    chk(doneViol == 0, "R9 done single cycle", doneViol, 0);
    chk(doneCount == 3, "R9 done count", doneCount, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule